// File: doc/BRIEF.md
# Packed-BCD Adder/Subtractor with Selectable Legacy Behaviour

This block is the arithmetic core of an 8-bit accumulator processor that offers add-with-carry and subtract-with-borrow in both binary and packed-BCD (decimal) form. It takes two byte operands, a carry input, an operation select and a decimal enable. It returns the byte result and the sign (N), overflow (V), zero (Z) and carry (C) flags. A module parameter picks one of three processor generations: the original NMOS part, its low-power CMOS successor, and a wider 16-bit-capable successor running in 8-bit mode. Each generation has its own decimal result and flag rules. These rules apply to every byte pair, including bytes with non-decimal nibbles A to F.

The result and flags are computed combinationally. They are captured in a single output register stage, so they are visible one clock after the inputs are applied. The carry input uses the usual convention: for subtraction, a 1 means no borrow is pending. Instruction decode, the register file and memory are outside the block.

Top module: `bcd_alu`

## Requirements
- R1: With decimal disabled and sub_i=0, the result is (A + B + carry_i) mod 256. C is bit 8 of that sum. V is set when A and B have the same sign bit and the result's sign bit differs from it. N is result bit 7. Z is set when the result is zero.
- R2: With decimal disabled and sub_i=1, the result is (A - B - (1 - carry_i)) mod 256. C=1 means no borrow occurred. V is set when A and B have different sign bits and the result's sign bit differs from A's. N and Z are taken from the result.
- R3: Decimal add, all variants. The low sum is A[3:0] + B[3:0] + carry_i. If it is 10 or more, it is raised by 6, kept to 4 bits, and a low carry is noted. The high sum is {A[7:4], adjusted low nibble} + (B & 0xF0), plus 0x10 when the low carry is set. If the high sum carries out of 8 bits or is at least 0xA0, 0x60 is added (mod 256) and C=1. Otherwise C=0.
- R4: Decimal add, all variants: V is the signed overflow of the high-sum addition, taken before the 0x60 correction. On the NMOS variant, N is bit 7 of that uncorrected high sum, and Z reflects the plain binary sum A + B + carry_i.
- R5: Decimal add on the CMOS and 16-bit variants: N is bit 7 of the final result and Z is set when the final result is zero.
- R6: Decimal subtract on the NMOS and 16-bit variants. The low difference is A[3:0] - B[3:0] - (1 - carry_i). On a low borrow, 6 is subtracted, the value is kept to 4 bits, and an extra 0x10 is subtracted from the high part. If the high difference {A[7:4], low nibble} - (B & 0xF0) - extra is negative, 0x60 is subtracted. The result is taken mod 256.
- R7: Decimal subtract on the CMOS variant. The low step only masks the nibble and passes the borrow on. The high step and the 0x60 correction are as in R6. Afterwards, 6 is subtracted from the whole byte when a low borrow occurred.
- R8: Decimal subtract on the NMOS variant: N, V, Z and C are exactly the flags the binary subtraction of R2 gives for the same inputs.
- R9: Decimal subtract on the CMOS and 16-bit variants: N and Z come from the decimal result, and V and C are the flags of the binary subtraction of R2.
- R10: While rst_n is low, the result and all four flags read zero. Outside reset, the outputs present the values computed from the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa_i | input | 8 | First operand (accumulator side) |
| opb_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry in; for subtraction 1 means no borrow |
| sub_i | input | 1 | 0 selects add, 1 selects subtract |
| dec_i | input | 1 | 1 selects packed-BCD arithmetic |
| acc_o | output | 8 | Registered result byte |
| flag_n_o | output | 1 | Registered sign flag |
| flag_v_o | output | 1 | Registered overflow flag |
| flag_z_o | output | 1 | Registered zero flag |
| flag_c_o | output | 1 | Registered carry flag (1 = no borrow on subtract) |

## Verification
The bound properties check the following on every clock:
- Binary add and subtract results and carries are exact.
- N and Z agree with the result byte everywhere except NMOS decimal operations.
- Decimal results stay valid BCD whenever both operands are valid BCD.
- The NMOS decimal-subtract carry equals the binary borrow.
- The outputs are cleared during reset.

Some behaviours are only shown by the bench's comparisons against its per-variant reference model:
- The exact bytes produced from invalid nibbles.
- V taken from the uncorrected high sum.
- The NMOS sign and zero flags drawn from intermediate or binary sums.
- The CMOS late subtraction of 6.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;

    // decimal nibble limit and correction constants
    localparam logic [NIB_W:0]    NIB_LIMIT = 5'd10;
    localparam logic [NIB_W-1:0]  NIB_FIX   = 4'd6;
    localparam logic [DATA_W-1:0] BYTE_LIM  = 8'hA0;
    localparam logic [DATA_W-1:0] HI_FIX    = 8'h60;
    localparam logic [DATA_W-1:0] LO_FIX_B  = 8'h06;

    typedef enum logic [1:0] {
        VAR_NMOS = 2'd0,
        VAR_CMOS = 2'd1,
        VAR_W16  = 2'd2
    } alu_variant_e;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              n;
        logic              v;
        logic              z;
        logic              c;
    } alu_res_t;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic              c;
        logic              v;
        logic              n_mid;
    } dec_add_t;

endpackage

// File: rtl/bcd_alu_bin.sv
module bcd_alu_bin
    import bcd_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output alu_res_t          res_o
);

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;

    always_comb begin
        // subtraction is addition of the inverted operand with carry as not-borrow
        b_eff      = sub_i ? ~b_i : b_i;
        wide       = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_i};
        res_o.acc  = wide[DATA_W-1:0];
        res_o.c    = wide[DATA_W];
        res_o.v    = (a_i[DATA_W-1] == b_eff[DATA_W-1]) &&
                     (wide[DATA_W-1] != a_i[DATA_W-1]);
        res_o.n    = wide[DATA_W-1];
        res_o.z    = (wide[DATA_W-1:0] == '0);
    end

endmodule

// File: rtl/bcd_alu_dec_add.sv
module bcd_alu_dec_add
    import bcd_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output dec_add_t          res_o
);

    logic [NIB_W:0]    lo_sum;
    logic              lo_carry;
    logic [NIB_W-1:0]  lo_fix;
    logic [DATA_W:0]   hi_sum;
    logic              hi_adj;

    always_comb begin
        lo_sum   = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} +
                   {{NIB_W{1'b0}}, cin_i};
        lo_carry = (lo_sum >= NIB_LIMIT);
        lo_fix   = lo_carry ? (lo_sum[NIB_W-1:0] + NIB_FIX) : lo_sum[NIB_W-1:0];

        // low carry enters the high part as an extra 0x10
        hi_sum   = {1'b0, a_i[DATA_W-1:NIB_W], lo_fix} +
                   {1'b0, b_i[DATA_W-1:NIB_W], {NIB_W{1'b0}}} +
                   {{NIB_W{1'b0}}, lo_carry, {NIB_W{1'b0}}};
        hi_adj   = hi_sum[DATA_W] | (hi_sum[DATA_W-1:0] >= BYTE_LIM);

        res_o.acc   = hi_adj ? (hi_sum[DATA_W-1:0] + HI_FIX) : hi_sum[DATA_W-1:0];
        res_o.c     = hi_adj;
        // overflow judged on the uncorrected high sum
        res_o.v     = (a_i[DATA_W-1] == b_i[DATA_W-1]) &&
                      (hi_sum[DATA_W-1] != a_i[DATA_W-1]);
        res_o.n_mid = hi_sum[DATA_W-1];
    end

endmodule

// File: rtl/bcd_alu_dec_sub.sv
module bcd_alu_dec_sub
    import bcd_alu_pkg::*;
#(
    parameter alu_variant_e VARIANT = VAR_NMOS
)(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] acc_o
);

    localparam bit LATE_FIX = (VARIANT == VAR_CMOS);

    logic [NIB_W:0]    lo_diff;
    logic              lo_borrow;
    logic [NIB_W-1:0]  lo_fix;
    logic [DATA_W:0]   hi_diff;
    logic [DATA_W-1:0] stage;

    always_comb begin
        lo_diff   = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]} -
                    {{NIB_W{1'b0}}, ~cin_i};
        lo_borrow = lo_diff[NIB_W];
        // early nibble correction only where the late one is absent
        lo_fix    = (lo_borrow && !LATE_FIX) ? (lo_diff[NIB_W-1:0] - NIB_FIX)
                                             : lo_diff[NIB_W-1:0];

        hi_diff   = {1'b0, a_i[DATA_W-1:NIB_W], lo_fix} -
                    {1'b0, b_i[DATA_W-1:NIB_W], {NIB_W{1'b0}}} -
                    {{NIB_W{1'b0}}, lo_borrow, {NIB_W{1'b0}}};
        stage     = hi_diff[DATA_W] ? (hi_diff[DATA_W-1:0] - HI_FIX)
                                    : hi_diff[DATA_W-1:0];
        acc_o     = (lo_borrow && LATE_FIX) ? (stage - LO_FIX_B) : stage;
    end

endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
    import bcd_alu_pkg::*;
#(
    parameter alu_variant_e VARIANT = VAR_NMOS
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  opa_i,
    input  logic [7:0]  opb_i,
    input  logic        carry_i,
    input  logic        sub_i,
    input  logic        dec_i,
    output logic [7:0]  acc_o,
    output logic        flag_n_o,
    output logic        flag_v_o,
    output logic        flag_z_o,
    output logic        flag_c_o
);

    localparam bit NMOS_FLAGS = (VARIANT == VAR_NMOS);

    alu_res_t          bin_res;
    dec_add_t          add_res;
    logic [DATA_W-1:0] sub_acc;
    alu_res_t          res_d;
    alu_res_t          res_q;

    bcd_alu_bin u_bin (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .cin_i (carry_i),
        .sub_i (sub_i),
        .res_o (bin_res)
    );

    bcd_alu_dec_add u_dadd (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .cin_i (carry_i),
        .res_o (add_res)
    );

    bcd_alu_dec_sub #(.VARIANT(VARIANT)) u_dsub (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .cin_i (carry_i),
        .acc_o (sub_acc)
    );

    always_comb begin
        res_d = bin_res;
        if (dec_i && !sub_i) begin
            res_d.acc = add_res.acc;
            res_d.c   = add_res.c;
            res_d.v   = add_res.v;
            res_d.n   = NMOS_FLAGS ? add_res.n_mid : add_res.acc[DATA_W-1];
            res_d.z   = NMOS_FLAGS ? bin_res.z     : (add_res.acc == '0);
        end else if (dec_i) begin
            // carry and overflow come from the binary subtraction
            res_d.acc = sub_acc;
            res_d.n   = NMOS_FLAGS ? bin_res.n : sub_acc[DATA_W-1];
            res_d.z   = NMOS_FLAGS ? bin_res.z : (sub_acc == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign acc_o    = res_q.acc;
    assign flag_n_o = res_q.n;
    assign flag_v_o = res_q.v;
    assign flag_z_o = res_q.z;
    assign flag_c_o = res_q.c;

endmodule

// File: rtl/bcd_alu_chk.sv
module bcd_alu_chk
    import bcd_alu_pkg::*;
#(
    parameter alu_variant_e VARIANT = VAR_NMOS
)(
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  opa_i,
    input logic [7:0]  opb_i,
    input logic        carry_i,
    input logic        sub_i,
    input logic        dec_i,
    input logic [7:0]  acc_o,
    input logic        flag_n_o,
    input logic        flag_v_o,
    input logic        flag_z_o,
    input logic        flag_c_o
);

    localparam bit IS_NMOS = (VARIANT == VAR_NMOS);

    // set once a full clock has passed outside reset
    logic live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    function automatic logic is_bcd(input logic [7:0] x);
        return (x[7:4] <= 4'd9) && (x[3:0] <= 4'd9);
    endfunction

    // R10: outputs cleared while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r10: assert (acc_o == 8'h00 && !flag_n_o && !flag_v_o &&
                                       !flag_z_o && !flag_c_o)
                else $error("outputs not cleared in reset");
        end
    end

    p_bin_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(!dec_i && !sub_i) |->
        {flag_c_o, acc_o} == ({1'b0, $past(opa_i)} + {1'b0, $past(opb_i)} +
                              {8'h00, $past(carry_i)}));

    p_bin_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(!dec_i && sub_i) |->
        {flag_c_o, acc_o} == ({1'b1, $past(opa_i)} - {1'b0, $past(opb_i)} -
                              {8'h00, !$past(carry_i)}));

    p_bcd_add_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(dec_i && !sub_i && is_bcd(opa_i) && is_bcd(opb_i)) |->
        is_bcd(acc_o));

    // covers R6 and R7: valid decimal operands give a valid decimal difference
    p_bcd_sub_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && $past(dec_i && sub_i && is_bcd(opa_i) && is_bcd(opb_i)) |->
        is_bcd(acc_o));

    // covers R5 and R9: sign and zero track the result byte
    p_flag_nz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && !(IS_NMOS && $past(dec_i)) |->
        (flag_n_o == acc_o[7]) && (flag_z_o == (acc_o == 8'h00)));

    p_nmos_sub_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        IS_NMOS && live_q && $past(dec_i && sub_i) |->
        flag_c_o == ({1'b0, $past(opa_i)} >= ({1'b0, $past(opb_i)} +
                                             {8'h00, !$past(carry_i)})));

endmodule

bind bcd_alu bcd_alu_chk #(.VARIANT(VARIANT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .carry_i  (carry_i),
    .sub_i    (sub_i),
    .dec_i    (dec_i),
    .acc_o    (acc_o),
    .flag_n_o (flag_n_o),
    .flag_v_o (flag_v_o),
    .flag_z_o (flag_z_o),
    .flag_c_o (flag_c_o)
);

// File: tb/bcd_alu_tb_top.sv
`timescale 1ns/1ps
module bcd_alu_tb_top;
    import bcd_alu_pkg::*;

    localparam int NVAR       = 3;
    localparam int N_RAND     = 30000;
    localparam int WD_CYCLES  = 150000;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] opa   = 8'h00;
    logic [7:0] opb   = 8'h00;
    logic       cin   = 1'b0;
    logic       sub   = 1'b0;
    logic       dec   = 1'b0;

    logic [7:0] acc_w [NVAR];
    logic       n_w   [NVAR];
    logic       v_w   [NVAR];
    logic       z_w   [NVAR];
    logic       c_w   [NVAR];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    bit have_prev = 1'b0;
    int p_a, p_b, p_c;
    bit p_s, p_d;

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < NVAR; g++) begin : g_var
        bcd_alu #(.VARIANT(alu_variant_e'(g))) dut_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .opa_i    (opa),
            .opb_i    (opb),
            .carry_i  (cin),
            .sub_i    (sub),
            .dec_i    (dec),
            .acc_o    (acc_w[g]),
            .flag_n_o (n_w[g]),
            .flag_v_o (v_w[g]),
            .flag_z_o (z_w[g]),
            .flag_c_o (c_w[g])
        );
    end

    // reference model written from the requirements; vi: 0 NMOS, 1 CMOS, 2 16-bit
    function automatic void model(input int vi, input int a, input int b, input int ci,
                                  input bit s, input bit d,
                                  output int r, output int n, output int v,
                                  output int z, output int c);
        int sum, lo, hi, bin_r, bin_n, bin_v, bin_z, bin_c, n_mid;
        bit lb;
        if (!s) sum = a + b + ci;
        else    sum = a - b - (1 - ci);
        bin_r = sum & 255;
        bin_c = s ? int'(sum >= 0) : int'(sum > 255);
        bin_n = (bin_r >> 7) & 1;
        bin_z = int'(bin_r == 0);
        if (!s) bin_v = int'((((a ^ bin_r) & (b ^ bin_r)) & 128) != 0);
        else    bin_v = int'((((a ^ b) & (a ^ bin_r)) & 128) != 0);
        if (!d) begin
            r = bin_r; n = bin_n; v = bin_v; z = bin_z; c = bin_c;
        end else if (!s) begin
            lo = (a & 15) + (b & 15) + ci;
            if (lo >= 10) lo = ((lo + 6) & 15) + 16;
            hi = (a & 240) + (b & 240) + lo;
            v  = int'((((a ^ hi) & ~(a ^ b)) & 128) != 0);
            n_mid = (hi >> 7) & 1;
            c = 0;
            if (hi >= 160) begin hi = hi + 96; c = 1; end
            r = hi & 255;
            if (vi == 0) begin n = n_mid; z = bin_z; end
            else begin n = (r >> 7) & 1; z = int'(r == 0); end
        end else begin
            lo = (a & 15) - (b & 15) - (1 - ci);
            lb = (lo < 0);
            if (lb) lo = (vi == 1) ? ((lo & 15) - 16) : (((lo - 6) & 15) - 16);
            hi = (a & 240) - (b & 240) + lo;
            if (hi < 0) hi = hi - 96;
            if (vi == 1 && lb) hi = hi - 6;
            r = hi & 255;
            v = bin_v; c = bin_c;
            if (vi == 0) begin n = bin_n; z = bin_z; end
            else begin n = (r >> 7) & 1; z = int'(r == 0); end
        end
    endfunction

    task automatic check_val(input string tag, input string what, input int vi,
                             input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s variant %0d a=%02h b=%02h cin=%0d sub=%0d dec=%0d: actual %0h expected %0h",
                     tag, what, vi, p_a, p_b, p_c, p_s, p_d, got, exp);
        end
    endtask

    // outputs seen one clock after the inputs were applied (R10 latency)
    task automatic compare_prev();
        for (int vi = 0; vi < NVAR; vi++) begin
            int r, n, v, z, c;
            string t_acc, t_c, t_v, t_nz;
            model(vi, p_a, p_b, p_c, p_s, p_d, r, n, v, z, c);
            if (!p_d) begin
                t_acc = p_s ? "R2" : "R1";
                t_c = t_acc; t_v = t_acc; t_nz = t_acc;
            end else if (!p_s) begin
                t_acc = "R3"; t_c = "R3"; t_v = "R4";
                t_nz  = (vi == 0) ? "R4" : "R5";
            end else begin
                t_acc = (vi == 1) ? "R7" : "R6";
                t_c   = (vi == 0) ? "R8" : "R9";
                t_v = t_c; t_nz = t_c;
            end
            check_val(t_acc, "result", vi, int'(acc_w[vi]), r);
            check_val(t_c,   "carry",  vi, int'(c_w[vi]), c);
            check_val(t_v,   "overflow", vi, int'(v_w[vi]), v);
            check_val(t_nz,  "sign",   vi, int'(n_w[vi]), n);
            check_val(t_nz,  "zero",   vi, int'(z_w[vi]), z);
        end
    endtask

    task automatic step(input int a, input int b, input int ci, input bit s, input bit d);
        @(negedge clk);
        if (have_prev) compare_prev();
        opa = a[7:0]; opb = b[7:0]; cin = ci[0]; sub = s; dec = d;
        p_a = a; p_b = b; p_c = ci; p_s = s; p_d = d;
        have_prev = 1'b1;
    endtask

    initial begin
        int bl [12] = '{8'h00, 8'h01, 8'h09, 8'h0A, 8'h0F, 8'h10,
                        8'h90, 8'h99, 8'h9A, 8'hA0, 8'hF0, 8'hFF};
        void'($urandom(32'd13579));
        // drive non-zero inputs during reset; outputs must still read zero
        opa = 8'hFF; opb = 8'h01; cin = 1'b1; dec = 1'b1;
        repeat (3) @(negedge clk);
        for (int vi = 0; vi < NVAR; vi++) begin
            check_val("R10", "reset result", vi, int'(acc_w[vi]), 0);
            check_val("R10", "reset flags", vi,
                      int'({n_w[vi], v_w[vi], z_w[vi], c_w[vi]}), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners: decimal carry chains, invalid nibbles, zero results
        step(8'h99, 8'h01, 0, 1'b0, 1'b1);   // R3 R4: NMOS Z from binary sum
        step(8'h99, 8'h00, 1, 1'b0, 1'b1);
        step(8'h50, 8'h50, 0, 1'b0, 1'b1);   // R4 overflow on intermediate
        step(8'hFF, 8'hFF, 1, 1'b0, 1'b1);   // R3 invalid nibbles
        step(8'h00, 8'h01, 1, 1'b1, 1'b1);   // R6 R7 borrow through both nibbles
        step(8'h10, 8'h01, 1, 1'b1, 1'b1);   // R7 late six
        step(8'h00, 8'h00, 0, 1'b1, 1'b1);   // R8 R9 borrow-in only
        step(8'h0A, 8'h00, 1, 1'b1, 1'b1);
        step(8'h7F, 8'h01, 0, 1'b0, 1'b0);   // R1 overflow
        step(8'h80, 8'h01, 1, 1'b1, 1'b0);   // R2 overflow
        step(8'h00, 8'h00, 1, 1'b1, 1'b0);   // R2 zero, no borrow

        // sweep every first operand against corner second operands
        for (int a = 0; a < 256; a++)
            for (int k = 0; k < 12; k++)
                for (int m = 0; m < 4; m++)
                    step(a, bl[k], m & 1, m[1], 1'b1);

        // random mix, mostly decimal
        for (int i = 0; i < N_RAND; i++)
            step(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                 int'($urandom_range(0, 1)), $urandom_range(0, 1) == 1,
                 $urandom_range(0, 3) != 0);

        @(negedge clk);
        compare_prev();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule